// File: doc/BRIEF.md
# 16-bit Pointer Arithmetic Unit

This unit computes the 16-bit address and stack-pointer arithmetic of a small 8-bit processor whose general registers are grouped in pairs. A single operation code selects one of seven jobs. The unit can add a register pair to the HL pair. It can add a signed 8-bit displacement to the stack pointer, with the sum going either back to the stack pointer or into HL. It can step a pair up or down by one. It also provides the HL post-increment and post-decrement used by memory accesses, where HL is first given out as the access address and then stepped.

The arithmetic itself is combinational. One register stage holds the result, the high and low bytes of the result, the access address, the updated flag nibble and a destination code. That stage is loaded whenever a request is strobed, and a valid strobe goes out one cycle after the request. The register file and the bus cycles sit outside the unit. The surrounding datapath writes the result to the destination the unit names and takes the flag nibble as the new flags.

Top module: `ptr_arith_unit`

## Requirements
- R1: A request on `in_valid` in one cycle raises `out_valid` in the next cycle only. The outputs hold their values while no request arrives. A synchronous reset clears every output to zero.
- R2: Op code 0 (pair add) produces `base + opnd` modulo 65536, with destination code 2 (HL).
- R3: For the pair add, H is the carry from bit 11 into bit 12 and C is the carry out of bit 15. N is cleared and Z passes through unchanged, including when the sum is zero. Flag nibble bit order is Z=3, N=2, H=1, C=0.
- R4: Op codes 1 and 2 (stack pointer plus displacement) sign-extend `opnd[7:0]`, ignore `opnd[15:8]`, and produce `base` plus the extended value modulo 65536.
- R5: For op codes 1 and 2, Z and N are forced to 0. H is the carry out of bit 3 and C is the carry out of bit 7 when the low byte of `base` and the displacement byte are added as unsigned values.
- R6: Op code 1 gives destination code 1 (SP). Op code 2 gives destination code 2 (HL). Both give the same result and flags for the same inputs.
- R7: Op codes 3 and 4 step `base` up or down by one with wraparound modulo 65536. The flags pass through unchanged and the destination code is 3 (the pair operated on).
- R8: Op codes 5 and 6 (HL post-step) output `base` as `addr` and step the result up or down by one with wraparound. The flags pass through unchanged and the destination code is 2. For every op code, `addr` equals the `base` of the request.
- R9: `res_hi` carries bits 15..8 of the result, for the first register of the pair. `res_lo` carries bits 7..0, for the second register.
- R10: Op code 7 is reserved. It returns `base` unchanged, leaves the flags unchanged and gives destination code 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0..7) |
| base | input | 16 | Base value: HL, SP or the pair being stepped |
| opnd | input | 16 | Pair operand, or the displacement in bits 7..0 |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 16 | 16-bit result |
| res_hi | output | 8 | Result high byte, for the first register of the pair |
| res_lo | output | 8 | Result low byte, for the second register of the pair |
| addr | output | 16 | Access address (the base of the request) |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |
| dest | output | 2 | Destination: 0 none, 1 SP, 2 HL, 3 same pair |

## Verification
Every fault in this unit shows at the ports on the cycle after the request, because the output register is the only state. A carry taken from the wrong bit position shows up as a wrong H or C only for operands whose nibble, byte or word boundary is crossed. For that reason the vectors cross each boundary in both directions, with the stack pointer near 0x0000 and 0xFFFF and displacements of -128, -1 and +127. A wrong hold or strobe path shows up as a stale or early `out_valid` in the idle cycle that follows a request.

// File: rtl/ptr_arith_pkg.sv
package ptr_arith_pkg;

    localparam int PA_W    = 16;
    localparam int DISP_W  = 8;
    localparam int BYTE_W  = PA_W / 2;
    localparam int FLAG_W  = 4;

    // Carry bit positions in the (a ^ b ^ sum) vector
    localparam int PAIR_H_BIT = 12;
    localparam int PAIR_C_BIT = PA_W;
    localparam int DISP_H_BIT = 4;
    localparam int DISP_C_BIT = DISP_W;

    typedef enum logic [2:0] {
        OP_PAIR_ADD    = 3'd0,
        OP_SP_DISP     = 3'd1,
        OP_SP_DISP_HL  = 3'd2,
        OP_STEP_UP     = 3'd3,
        OP_STEP_DN     = 3'd4,
        OP_HL_POST_UP  = 3'd5,
        OP_HL_POST_DN  = 3'd6,
        OP_RSVD        = 3'd7
    } pa_op_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_SP   = 2'd1,
        DST_HL   = 2'd2,
        DST_PAIR = 2'd3
    } pa_dst_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } pa_flags_t;

    typedef struct packed {
        logic [PA_W-1:0] sum;
        logic [PA_W-1:0] addr;
        pa_flags_t       fl;
        pa_dst_e         dst;
    } pa_out_t;

    function automatic logic is_disp_op(input pa_op_e o);
        return (o == OP_SP_DISP) || (o == OP_SP_DISP_HL);
    endfunction

endpackage

// File: rtl/ptr_sext.sv
module ptr_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int EXT_W = OUT_W - IN_W;

    generate
        if (EXT_W > 0) begin : g_ext
            assign dout = {{EXT_W{din[IN_W-1]}}, din};
        end else begin : g_pass
            assign dout = din[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ptr_carry_add.sv
module ptr_carry_add #(
    parameter int W     = 16,
    parameter int H_BIT = 12,
    parameter int C_BIT = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         h_out,
    output logic         c_out
);
    logic [W:0] wide;
    logic [W:0] carries;

    // carries[k] is the carry that entered bit k
    assign wide    = {1'b0, a} + {1'b0, b};
    assign carries = {1'b0, a} ^ {1'b0, b} ^ wide;
    assign sum     = wide[W-1:0];
    assign h_out   = carries[H_BIT];
    assign c_out   = carries[C_BIT];
endmodule

// File: rtl/ptr_step.sv
module ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    assign nxt = down ? (base - ONE) : (base + ONE);
endmodule

// File: rtl/ptr_arith_unit.sv
module ptr_arith_unit
    import ptr_arith_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [PA_W-1:0]   base,
    input  logic [PA_W-1:0]   opnd,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [PA_W-1:0]   result,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic [PA_W-1:0]   addr,
    output logic [FLAG_W-1:0] flags_out,
    output logic [1:0]        dest
);

    pa_op_e    op_e;
    pa_flags_t fl_in;
    assign op_e  = pa_op_e'(op);
    assign fl_in = pa_flags_t'(flags_in);

    // Pair + pair
    logic [PA_W-1:0] pair_sum;
    logic            pair_h, pair_c;
    ptr_carry_add #(.W(PA_W), .H_BIT(PAIR_H_BIT), .C_BIT(PAIR_C_BIT)) u_pair_add (
        .a     (base),
        .b     (opnd),
        .sum   (pair_sum),
        .h_out (pair_h),
        .c_out (pair_c)
    );

    // SP + signed displacement
    logic [PA_W-1:0] disp_ext;
    ptr_sext #(.IN_W(DISP_W), .OUT_W(PA_W)) u_sext (
        .din  (opnd[DISP_W-1:0]),
        .dout (disp_ext)
    );

    logic [PA_W-1:0] disp_sum;
    logic            disp_h, disp_c;
    ptr_carry_add #(.W(PA_W), .H_BIT(DISP_H_BIT), .C_BIT(DISP_C_BIT)) u_disp_add (
        .a     (base),
        .b     (disp_ext),
        .sum   (disp_sum),
        .h_out (disp_h),
        .c_out (disp_c)
    );

    // +/-1 stepper shared by pair steps and HL post-steps
    logic            step_down;
    logic [PA_W-1:0] step_nxt;
    assign step_down = (op_e == OP_STEP_DN) || (op_e == OP_HL_POST_DN);
    ptr_step #(.W(PA_W)) u_step (
        .base (base),
        .down (step_down),
        .nxt  (step_nxt)
    );

    pa_out_t nxt;
    always_comb begin
        nxt.sum  = base;
        nxt.addr = base;
        nxt.fl   = fl_in;
        nxt.dst  = DST_NONE;
        case (op_e)
            OP_PAIR_ADD: begin
                nxt.sum  = pair_sum;
                nxt.fl.n = 1'b0;
                nxt.fl.h = pair_h;
                nxt.fl.c = pair_c;
                nxt.dst  = DST_HL;
            end
            OP_SP_DISP, OP_SP_DISP_HL: begin
                nxt.sum  = disp_sum;
                nxt.fl.z = 1'b0;
                nxt.fl.n = 1'b0;
                nxt.fl.h = disp_h;
                nxt.fl.c = disp_c;
                nxt.dst  = (op_e == OP_SP_DISP) ? DST_SP : DST_HL;
            end
            OP_STEP_UP, OP_STEP_DN: begin
                nxt.sum = step_nxt;
                nxt.dst = DST_PAIR;
            end
            OP_HL_POST_UP, OP_HL_POST_DN: begin
                nxt.sum = step_nxt;
                nxt.dst = DST_HL;
            end
            default: begin
                nxt.sum = base;
            end
        endcase
    end

    pa_out_t q;
    logic    vld_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                q <= nxt;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = q.sum;
    assign res_hi    = q.sum[PA_W-1:BYTE_W];
    assign res_lo    = q.sum[BYTE_W-1:0];
    assign addr      = q.addr;
    assign flags_out = q.fl;
    assign dest      = q.dst;

endmodule

// File: rtl/ptr_arith_chk.sv
module ptr_arith_chk
    import ptr_arith_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [PA_W-1:0]   base,
    input logic [FLAG_W-1:0] flags_in,
    input logic              out_valid,
    input logic [PA_W-1:0]   result,
    input logic [PA_W-1:0]   addr,
    input logic [FLAG_W-1:0] flags_out
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    pair_zn_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0) |=>
            (flags_out[2] == 1'b0) && (flags_out[3] == $past(flags_in[3])));

    // R5
    disp_zn_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd1 || op == 3'd2)) |=> (flags_out[3:2] == 2'b00));

    // R7
    step_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 3'd3 && op <= 3'd6) |=> (flags_out == $past(flags_in)));

    // R7
    step_up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3) |=> (result == $past(base) + 16'd1));

    // R8
    post_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 3'd5 || op == 3'd6)) |=> (addr == $past(base)));

    // R10
    rsvd_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd7) |=> (result == $past(base)));
endmodule

bind ptr_arith_unit ptr_arith_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .base      (base),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .addr      (addr),
    .flags_out (flags_out)
);

// File: tb/tb_ptr_arith_unit.sv
module tb_ptr_arith_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [15:0] base;
    logic [15:0] opnd;
    logic [3:0]  flags_in;
    logic        out_valid;
    logic [15:0] result;
    logic [7:0]  res_hi;
    logic [7:0]  res_lo;
    logic [15:0] addr;
    logic [3:0]  flags_out;
    logic [1:0]  dest;

    always #2.5 clk = ~clk;   // 200 MHz

    ptr_arith_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .base(base),
        .opnd(opnd), .flags_in(flags_in), .out_valid(out_valid),
        .result(result), .res_hi(res_hi), .res_lo(res_lo), .addr(addr),
        .flags_out(flags_out), .dest(dest)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0:       return "R2 R3";
            3'd1, 3'd2: return "R4 R5 R6";
            3'd3, 3'd4: return "R7";
            3'd5, 3'd6: return "R8";
            default:    return "R10";
        endcase
    endfunction

    // {op, base, opnd, flags_in(ZNHC), exp_result, exp_flags, exp_dest}
    localparam int NV = 17;
    localparam logic [60:0] VEC [NV] = '{
        {3'd0, 16'h0FFF, 16'h0001, 4'b1000, 16'h1000, 4'b1010, 2'd2}, // R3 half carry, Z kept
        {3'd0, 16'h8000, 16'h8000, 4'b0100, 16'h0000, 4'b0001, 2'd2}, // R3 zero sum leaves Z
        {3'd0, 16'h1234, 16'h1111, 4'b0011, 16'h2345, 4'b0000, 2'd2}, // R2 no carries
        {3'd0, 16'hFFFF, 16'hFFFF, 4'b0000, 16'hFFFE, 4'b0011, 2'd2}, // R3 both carries
        {3'd1, 16'hFFF8, 16'h0008, 4'b1100, 16'h0000, 4'b0011, 2'd1}, // R5 Z forced 0
        {3'd1, 16'h0000, 16'h5A80, 4'b1111, 16'hFF80, 4'b0000, 2'd1}, // R4 -128, high byte ignored
        {3'd2, 16'hFFFF, 16'h007F, 4'b1000, 16'h007E, 4'b0011, 2'd2}, // R6 +127 into HL
        {3'd2, 16'h0001, 16'h00FF, 4'b0000, 16'h0000, 4'b0011, 2'd2}, // R5 -1 carries
        {3'd1, 16'hFFFF, 16'h0080, 4'b0000, 16'hFF7F, 4'b0001, 2'd1}, // R5 C without H
        {3'd1, 16'h0000, 16'h007F, 4'b0000, 16'h007F, 4'b0000, 2'd1}, // R4 +127 from 0
        {3'd3, 16'hFFFF, 16'h0000, 4'b1010, 16'h0000, 4'b1010, 2'd3}, // R7 up wrap
        {3'd4, 16'h0000, 16'h0000, 4'b0101, 16'hFFFF, 4'b0101, 2'd3}, // R7 down wrap
        {3'd3, 16'h12FF, 16'hFFFF, 4'b0000, 16'h1300, 4'b0000, 2'd3}, // R7 byte ripple
        {3'd5, 16'hFFFF, 16'h0000, 4'b1001, 16'h0000, 4'b1001, 2'd2}, // R8 post up wrap
        {3'd6, 16'h0000, 16'h0000, 4'b0110, 16'hFFFF, 4'b0110, 2'd2}, // R8 post down wrap
        {3'd6, 16'hC000, 16'h0000, 4'b0000, 16'hBFFF, 4'b0000, 2'd2}, // R8 post down
        {3'd7, 16'hABCD, 16'h1234, 4'b1111, 16'hABCD, 4'b1111, 2'd0}  // R10 reserved
    };

    task automatic report;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; base = '0; opnd = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "reset result", {16'd0, result}, 32'd0);
        chk("R1", "reset flags", {28'd0, flags_out}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] vo;
            logic [15:0] vb, vn, er;
            logic [3:0] vf, ef;
            logic [1:0] ed;
            {vo, vb, vn, vf, er, ef, ed} = VEC[i];
            op = vo; base = vb; opnd = vn; flags_in = vf; in_valid = 1'b1;
            @(negedge clk);
            chk("R1", "out_valid", {31'd0, out_valid}, 32'd1);
            chk(req_of(vo), "result", {16'd0, result}, {16'd0, er});
            chk(req_of(vo), "flags", {28'd0, flags_out}, {28'd0, ef});
            chk(req_of(vo), "dest", {30'd0, dest}, {30'd0, ed});
            chk("R8", "addr", {16'd0, addr}, {16'd0, vb});
            chk("R9", "byte split", {16'd0, res_hi, res_lo}, {16'd0, er});
        end

        // R1 idle cycle: strobe drops, outputs hold
        in_valid = 1'b0; op = 3'd0; base = 16'h5555; opnd = 16'h5555; flags_in = 4'b0000;
        @(negedge clk);
        chk("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "idle hold result", {16'd0, result}, 32'h0000ABCD);
        chk("R1", "idle hold flags", {28'd0, flags_out}, 32'hF);

        // R6 same inputs to both displacement forms
        in_valid = 1'b1; op = 3'd1; base = 16'h00F0; opnd = 16'h0018; flags_in = 4'b1111;
        @(negedge clk);
        chk("R6", "disp to SP result", {16'd0, result}, 32'h0108);
        chk("R6", "disp to SP flags", {28'd0, flags_out}, 32'h1);
        chk("R6", "disp to SP dest", {30'd0, dest}, 32'd1);
        op = 3'd2;
        @(negedge clk);
        chk("R6", "disp to HL result", {16'd0, result}, 32'h0108);
        chk("R6", "disp to HL flags", {28'd0, flags_out}, 32'h1);
        chk("R6", "disp to HL dest", {30'd0, dest}, 32'd2);

        // R1 reset mid-run clears outputs
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "rerst result", {16'd0, result}, 32'd0);
        chk("R1", "rerst dest", {30'd0, dest}, 32'd0);
        chk("R1", "rerst out_valid", {31'd0, out_valid}, 32'd0);

        @(negedge clk);
        report();
    end

endmodule